// File: doc/BRIEF.md
# Flash-to-FPGA Configuration Sequencer

This block copies a configuration image out of an asynchronous parallel flash and feeds it, one byte at a time, into the passive configuration port of a target FPGA. It first pulses the target's active-low configuration request, then waits for the target's status line to go high. It fetches each byte from flash, waiting a fixed access latency. It places the byte on the configuration data bus and gives one configuration clock pulse per byte. After the last byte it sends a few trailing clock pulses and waits for the target's done line.

The image is selected by a page input. The start address is the page number shifted left by a page-size exponent. The image length is fixed by a parameter.

The sequencer only runs while an external arbiter grants it the flash. Losing the grant while it runs releases the flash bus at once and ends in an error state. A low status line while data moves also ends in the error state, as does a done line that never rises. From the error or done state, a restart request starts a new load if the grant is present. An asynchronous active-low reset returns the block to idle.

Top module: `cfgseq_top`

## Requirements
- R1: While `rst_n` is low the block is idle: `cfg_nconfig_o`=1, `cfg_dclk_o`=0, `flash_ce_n_o`=`flash_oe_n_o`=1, `flash_drive_o`=0, and `busy_o`, `done_o` and `err_o` are 0. This holds in the same cycle, including when reset is asserted in the middle of a load.
- R2: While `grant_i` is low, no load starts from idle. `flash_ce_n_o`, `flash_oe_n_o` and `flash_drive_o` are inactive in the same cycle. If the grant drops while `busy_o`=1, the block is in the error state on the next cycle.
- R3: A load begins on the clock edge where the start condition holds. After that edge, `cfg_nconfig_o` is 0 for exactly NCFG_CYC cycles. During those cycles there is no flash access and no configuration clock.
- R4: After the request pulse, the block reads no flash data until `tgt_status_i` is high. If status stays low for TIMEOUT cycles, the block enters the error state.
- R5: The flash address for byte k is (page << PAGE_EXP) + k. The page is taken from `page_i` at the start edge.
- R6: Each byte read holds `flash_ce_n_o`=`flash_oe_n_o`=0 for RD_LAT cycles. The data is captured at the end of the last of those cycles.
- R7: Each captured byte is shown on `cfg_data_o`, with the most significant bit on bit 7, for 2*CLK_HALF cycles. During this window `cfg_dclk_o` is low for the first CLK_HALF cycles and high for the next CLK_HALF cycles. The data does not change while the clock is high.
- R8: If `tgt_status_i` is low while a byte is read, shifted, or while the block waits for done, the block enters the error state on the next cycle.
- R9: After the last of IMG_BYTES bytes, the block gives EXTRA_CLK further configuration clock pulses of the same shape. It then waits for done. If `tgt_done_i` is high in this phase, `done_o` is 1 from the next cycle on.
- R10: If done does not rise within TIMEOUT cycles of the last byte, the block enters the error state.
- R11: In the error state, `err_o`=1, the flash bus is released and `cfg_nconfig_o`=1. From the error or done state, `restart_i` together with `grant_i` starts a new load, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Flash access grant from the arbiter |
| restart_i | input | 1 | Restart request from the done or error state |
| page_i | input | PAGE_W | Image page select |
| tgt_status_i | input | 1 | Target status line (high = ready, low = error) |
| tgt_done_i | input | 1 | Target done line |
| flash_addr_o | output | ADDR_W | Flash byte address |
| flash_data_i | input | 8 | Flash read data |
| flash_ce_n_o | output | 1 | Flash chip enable, active low |
| flash_oe_n_o | output | 1 | Flash output enable, active low |
| flash_drive_o | output | 1 | High while the block drives the flash address and control lines |
| cfg_nconfig_o | output | 1 | Configuration request to the target, active low |
| cfg_dclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data byte |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished successfully |
| err_o | output | 1 | Load aborted |

## Verification
The bench builds the block with a 12-bit address, a 256-byte page, a 5-byte image, a 3-cycle request pulse, a 2-cycle read latency, a half period of 2 and 3 trailing pulses. It uses a 30-cycle timeout. These small values let one run reach every page boundary, the last-byte turn into the trailing pulses, and both timeouts. A behavioural model is compared with every output on every cycle. Its runs cover a status line that rises late, a status loss mid-byte, a grant dropped during a read, a done line that never comes, and reset during a load.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_NCFG  = 3'd1,
      ST_WSTAT = 3'd2,
      ST_READ  = 3'd3,
      ST_SHIFT = 3'd4,
      ST_WDONE = 3'd5,
      ST_DONE  = 3'd6,
      ST_ERR   = 3'd7
   } seq_state_t;

   function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/cfgseq_cnt.sv
module cfgseq_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] val
);

   if (W < 1) begin : g_bad_w
      $error("cfgseq_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= '0;
      else if (clr) val <= '0;
      else if (inc) val <= val + 1'b1;
   end

endmodule

// File: rtl/cfgseq_dpath.sv
module cfgseq_dpath #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned PAGE_W    = 2,
   parameter int unsigned PAGE_EXP  = 20,
   parameter int unsigned IMG_BYTES = 4096,
   parameter bit          BIT_REV   = 1'b0,
   localparam int unsigned IDX_W    = $clog2(IMG_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              page_ld,
   input  logic              idx_clr,
   input  logic              idx_inc,
   input  logic              latch_en,
   input  logic [7:0]        flash_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        data_o,
   output logic              last_o
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(IMG_BYTES - 1);

   if (PAGE_W + PAGE_EXP > ADDR_W) begin : g_bad_page
      $error("cfgseq_dpath: page field does not fit in the address");
   end
   if (IMG_BYTES < 1) begin : g_bad_img
      $error("cfgseq_dpath: IMG_BYTES must be at least 1");
   end

   logic [PAGE_W-1:0] page_q;
   logic [IDX_W-1:0]  idx_q;
   logic [7:0]        byte_q;
   logic [7:0]        byte_ord;
   logic [ADDR_W-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q <= '0;
      else if (page_ld) page_q <= page_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (idx_clr) idx_q <= '0;
      else if (idx_inc) idx_q <= idx_q + 1'b1;
   end

   generate
      if (BIT_REV) begin : g_rev
         for (genvar b = 0; b < 8; b++) begin : g_bit
            assign byte_ord[b] = flash_data_i[7-b];
         end
      end else begin : g_fwd
         assign byte_ord = flash_data_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q <= '0;
      else if (latch_en) byte_q <= byte_ord;
   end

   assign base   = ADDR_W'(page_q) << PAGE_EXP;
   assign addr_o = base + ADDR_W'(idx_q);
   assign data_o = byte_q;
   assign last_o = (idx_q == IDX_LAST);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_inc && !idx_clr && !page_ld) |=> (addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
   import cfgseq_pkg::*;
#(
   parameter int unsigned NCFG_CYC  = 8,
   parameter int unsigned RD_LAT    = 3,
   parameter int unsigned CLK_HALF  = 2,
   parameter int unsigned EXTRA_CLK = 8,
   parameter int unsigned TIMEOUT   = 100000,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TMO_W     = 17,
   parameter int unsigned PUL_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant_i,
   input  logic             restart_i,
   input  logic             status_i,
   input  logic             done_i,
   input  logic             last_i,
   input  logic [CNT_W-1:0] cnt,
   input  logic [TMO_W-1:0] tmo,
   input  logic [PUL_W-1:0] pul,
   output seq_state_t       st_o,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             tmo_clr,
   output logic             tmo_inc,
   output logic             pul_clr,
   output logic             pul_inc,
   output logic             page_ld,
   output logic             idx_clr,
   output logic             idx_inc,
   output logic             latch_en
);

   localparam logic [CNT_W-1:0] NCFG_END  = CNT_W'(NCFG_CYC - 1);
   localparam logic [CNT_W-1:0] RD_END    = CNT_W'(RD_LAT - 1);
   localparam logic [CNT_W-1:0] SHIFT_END = CNT_W'(2 * CLK_HALF - 1);
   localparam logic [TMO_W-1:0] TMO_END   = TMO_W'(TIMEOUT - 1);
   localparam logic [PUL_W-1:0] PUL_NUM   = PUL_W'(EXTRA_CLK);

   seq_state_t st, nxt;
   logic       active, moving, abort, start_req, pul_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   assign active    = (st == ST_NCFG) || (st == ST_WSTAT) || (st == ST_READ) ||
                      (st == ST_SHIFT) || (st == ST_WDONE);
   assign moving    = (st == ST_READ) || (st == ST_SHIFT) || (st == ST_WDONE);
   assign abort     = (active && !grant_i) || (moving && !status_i);
   assign start_req = grant_i && ((st == ST_IDLE) ||
                      (((st == ST_DONE) || (st == ST_ERR)) && restart_i));
   assign pul_left  = (pul < PUL_NUM);

   always_comb begin
      nxt      = st;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      tmo_clr  = 1'b0;
      tmo_inc  = 1'b0;
      pul_clr  = 1'b0;
      pul_inc  = 1'b0;
      page_ld  = 1'b0;
      idx_clr  = 1'b0;
      idx_inc  = 1'b0;
      latch_en = 1'b0;
      if (abort) begin
         nxt = ST_ERR;
      end else begin
         unique case (st)
            ST_IDLE, ST_DONE, ST_ERR: begin
               if (start_req) begin
                  nxt     = ST_NCFG;
                  cnt_clr = 1'b1;
                  page_ld = 1'b1;
                  idx_clr = 1'b1;
               end
            end
            ST_NCFG: begin
               if (cnt == NCFG_END) begin
                  nxt     = ST_WSTAT;
                  cnt_clr = 1'b1;
                  tmo_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_WSTAT: begin
               if (status_i) begin
                  nxt     = ST_READ;
                  cnt_clr = 1'b1;
               end else if (tmo == TMO_END) begin
                  nxt = ST_ERR;
               end else begin
                  tmo_inc = 1'b1;
               end
            end
            ST_READ: begin
               if (cnt == RD_END) begin
                  latch_en = 1'b1;
                  nxt      = ST_SHIFT;
                  cnt_clr  = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_SHIFT: begin
               if (cnt == SHIFT_END) begin
                  cnt_clr = 1'b1;
                  if (last_i) begin
                     nxt     = ST_WDONE;
                     tmo_clr = 1'b1;
                     pul_clr = 1'b1;
                  end else begin
                     idx_inc = 1'b1;
                     nxt     = ST_READ;
                  end
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_WDONE: begin
               if (done_i)                nxt = ST_DONE;
               else if (tmo == TMO_END)   nxt = ST_ERR;
               else                       tmo_inc = 1'b1;
               if (pul_left) begin
                  if (cnt == SHIFT_END) begin
                     cnt_clr = 1'b1;
                     pul_inc = 1'b1;
                  end else begin
                     cnt_inc = 1'b1;
                  end
               end
            end
            default: nxt = ST_ERR;
         endcase
      end
   end

   assign st_o = st;

   // R4
   wait_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WSTAT && !status_i && grant_i && tmo != TMO_END) |=> (st == ST_WSTAT));

   // R11
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERR && !(restart_i && grant_i)) |=> (st == ST_ERR));

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
   import cfgseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned PAGE_W    = 2,
   parameter int unsigned PAGE_EXP  = 20,
   parameter int unsigned IMG_BYTES = 4096,
   parameter int unsigned NCFG_CYC  = 8,
   parameter int unsigned RD_LAT    = 3,
   parameter int unsigned CLK_HALF  = 2,
   parameter int unsigned EXTRA_CLK = 8,
   parameter int unsigned TIMEOUT   = 100000,
   parameter bit          BIT_REV   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_i,
   input  logic              restart_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              tgt_status_i,
   input  logic              tgt_done_i,
   output logic [ADDR_W-1:0] flash_addr_o,
   input  logic [7:0]        flash_data_i,
   output logic              flash_ce_n_o,
   output logic              flash_oe_n_o,
   output logic              flash_drive_o,
   output logic              cfg_nconfig_o,
   output logic              cfg_dclk_o,
   output logic [7:0]        cfg_data_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int unsigned CNT_MAX = max_of3(NCFG_CYC, RD_LAT, 2 * CLK_HALF);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX) + 1;
   localparam int unsigned TMO_W   = $clog2(TIMEOUT) + 1;
   localparam int unsigned PUL_W   = $clog2(EXTRA_CLK + 1) + 1;
   localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(CLK_HALF);
   localparam logic [PUL_W-1:0] EXTRA_V = PUL_W'(EXTRA_CLK);

   if (NCFG_CYC < 1 || RD_LAT < 1 || CLK_HALF < 1) begin : g_bad_timing
      $error("cfgseq_top: NCFG_CYC, RD_LAT and CLK_HALF must be at least 1");
   end
   if (EXTRA_CLK < 1 || TIMEOUT < 2) begin : g_bad_tail
      $error("cfgseq_top: EXTRA_CLK must be at least 1 and TIMEOUT at least 2");
   end

   seq_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic [TMO_W-1:0] tmo;
   logic [PUL_W-1:0] pul;
   logic cnt_clr, cnt_inc, tmo_clr, tmo_inc, pul_clr, pul_inc;
   logic page_ld, idx_clr, idx_inc, latch_en, last_byte;
   logic rd_phase, high_half;

   cfgseq_fsm #(
      .NCFG_CYC (NCFG_CYC),
      .RD_LAT   (RD_LAT),
      .CLK_HALF (CLK_HALF),
      .EXTRA_CLK(EXTRA_CLK),
      .TIMEOUT  (TIMEOUT),
      .CNT_W    (CNT_W),
      .TMO_W    (TMO_W),
      .PUL_W    (PUL_W)
   ) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant_i  (grant_i),
      .restart_i(restart_i),
      .status_i (tgt_status_i),
      .done_i   (tgt_done_i),
      .last_i   (last_byte),
      .cnt      (cnt),
      .tmo      (tmo),
      .pul      (pul),
      .st_o     (st),
      .cnt_clr  (cnt_clr),
      .cnt_inc  (cnt_inc),
      .tmo_clr  (tmo_clr),
      .tmo_inc  (tmo_inc),
      .pul_clr  (pul_clr),
      .pul_inc  (pul_inc),
      .page_ld  (page_ld),
      .idx_clr  (idx_clr),
      .idx_inc  (idx_inc),
      .latch_en (latch_en)
   );

   cfgseq_cnt #(.W(CNT_W)) i_phase_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .val(cnt));

   cfgseq_cnt #(.W(TMO_W)) i_tmo_cnt (
      .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .inc(tmo_inc), .val(tmo));

   cfgseq_cnt #(.W(PUL_W)) i_pulse_cnt (
      .clk(clk), .rst_n(rst_n), .clr(pul_clr), .inc(pul_inc), .val(pul));

   cfgseq_dpath #(
      .ADDR_W   (ADDR_W),
      .PAGE_W   (PAGE_W),
      .PAGE_EXP (PAGE_EXP),
      .IMG_BYTES(IMG_BYTES),
      .BIT_REV  (BIT_REV)
   ) i_dpath (
      .clk         (clk),
      .rst_n       (rst_n),
      .page_i      (page_i),
      .page_ld     (page_ld),
      .idx_clr     (idx_clr),
      .idx_inc     (idx_inc),
      .latch_en    (latch_en),
      .flash_data_i(flash_data_i),
      .addr_o      (flash_addr_o),
      .data_o      (cfg_data_o),
      .last_o      (last_byte)
   );

   assign rd_phase      = grant_i && (st == ST_READ);
   assign high_half     = (cnt >= HALF_V);
   assign flash_ce_n_o  = !rd_phase;
   assign flash_oe_n_o  = !rd_phase;
   assign flash_drive_o = grant_i && ((st == ST_READ) || (st == ST_SHIFT));
   assign cfg_nconfig_o = (st != ST_NCFG);
   assign cfg_dclk_o    = high_half && ((st == ST_SHIFT) ||
                          ((st == ST_WDONE) && (pul < EXTRA_V)));
   assign busy_o        = (st == ST_NCFG) || (st == ST_WSTAT) || (st == ST_READ) ||
                          (st == ST_SHIFT) || (st == ST_WDONE);
   assign done_o        = (st == ST_DONE);
   assign err_o         = (st == ST_ERR);

   // R2
   grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !grant_i) |=> err_o);

   // R8
   status_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_i && !tgt_status_i && (st == ST_READ || st == ST_SHIFT || st == ST_WDONE))
      |=> err_o);

   // R11
   err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (flash_ce_n_o && flash_oe_n_o && !flash_drive_o && cfg_nconfig_o));

   // R7
   dclk_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dclk_o |-> $stable(cfg_data_o));

   // R3
   ncfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_nconfig_o |-> (flash_ce_n_o && !cfg_dclk_o && !flash_drive_o));

   // R9
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(tgt_done_i));

endmodule

// File: tb/test_cfgseq_top.sv
module test_cfgseq_top;

   localparam int AW = 12, PW = 2, PE = 8, IMG = 5, NC = 3, RL = 2, H = 2, EX = 3, TO = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grant = 1'b0, restart = 1'b0, status = 1'b0, done = 1'b0;
   logic [PW-1:0] page = '0;
   logic [AW-1:0] faddr;
   logic [7:0] fdata, cdata;
   logic ce_n, oe_n, drive, ncfg, dclk, busy, done_o, err_o;

   int checks = 0, failures = 0, cycles = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [7:0] fmem(input int a);
      logic [7:0] lo, pg;
      lo = 8'(a);
      pg = 8'(a >> 8);
      return 8'(lo * 8'd7 + pg * 8'h31 + 8'h11);
   endfunction

   assign fdata = fmem(int'(faddr));

   cfgseq_top #(
      .ADDR_W(AW), .PAGE_W(PW), .PAGE_EXP(PE), .IMG_BYTES(IMG), .NCFG_CYC(NC),
      .RD_LAT(RL), .CLK_HALF(H), .EXTRA_CLK(EX), .TIMEOUT(TO), .BIT_REV(1'b0)
   ) i_cfgseq_top (
      .clk(clk), .rst_n(rst_n), .grant_i(grant), .restart_i(restart), .page_i(page),
      .tgt_status_i(status), .tgt_done_i(done), .flash_addr_o(faddr),
      .flash_data_i(fdata), .flash_ce_n_o(ce_n), .flash_oe_n_o(oe_n),
      .flash_drive_o(drive), .cfg_nconfig_o(ncfg), .cfg_dclk_o(dclk),
      .cfg_data_o(cdata), .busy_o(busy), .done_o(done_o), .err_o(err_o)
   );

   // behavioural reference: 0 idle,1 request,2 wait status,3 read,4 shift,5 wait done,6 done,7 error
   int ms = 0, mcnt = 0, mtmo = 0, mpul = 0, midx = 0, mpage = 0;
   logic [7:0] mdata = 8'h00;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms = 0; mcnt = 0; mtmo = 0; mpul = 0; midx = 0; mpage = 0; mdata = 8'h00;
      end else if ((ms >= 1 && ms <= 5) && !grant) begin
         ms = 7;
      end else if ((ms >= 3 && ms <= 5) && !status) begin
         ms = 7;
      end else begin
         case (ms)
            0, 6, 7: if (grant && (ms == 0 || restart)) begin
               ms = 1; mcnt = 0; mpage = int'(page); midx = 0;
            end
            1: if (mcnt == NC - 1) begin ms = 2; mcnt = 0; mtmo = 0; end else mcnt++;
            2: if (status) begin ms = 3; mcnt = 0; end
               else if (mtmo == TO - 1) ms = 7; else mtmo++;
            3: if (mcnt == RL - 1) begin
                  mdata = fmem((mpage << PE) + midx); ms = 4; mcnt = 0;
               end else mcnt++;
            4: if (mcnt == 2 * H - 1) begin
                  mcnt = 0;
                  if (midx == IMG - 1) begin ms = 5; mtmo = 0; mpul = 0; end
                  else begin midx++; ms = 3; end
               end else mcnt++;
            5: begin
                  if (done) ms = 6; else if (mtmo == TO - 1) ms = 7; else mtmo++;
                  if (mpul < EX) begin
                     if (mcnt == 2 * H - 1) begin mcnt = 0; mpul++; end else mcnt++;
                  end
               end
            default: ms = 7;
         endcase
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, away from the clock edge
   always @(negedge clk) begin
      if (!finished) begin
         chk("R3 nconfig", int'(ncfg), int'(ms != 1));
         chk("R7 dclk", int'(dclk), int'(((ms == 4) || (ms == 5 && mpul < EX)) && mcnt >= H));
         chk("R7 data", int'(cdata), int'(mdata));
         chk("R6 ce_n", int'(ce_n), int'(!(grant && ms == 3)));
         chk("R6 oe_n", int'(oe_n), int'(!(grant && ms == 3)));
         chk("R2 drive", int'(drive), int'(grant && (ms == 3 || ms == 4)));
         if (ms == 3 || ms == 4) chk("R5 addr", int'(faddr), (mpage << PE) + midx);
         chk("R9 done", int'(done_o), int'(ms == 6));
         chk("R11 err", int'(err_o), int'(ms == 7));
         chk("R1 busy", int'(busy), int'(ms >= 1 && ms <= 5));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic wait_state(input int s);
      while (ms != s) cyc(1);
   endtask

   task automatic pulse_restart();
      restart = 1'b1; cyc(1); restart = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #30;
      // R1 idle during reset
      chk("R1 reset nconfig", int'(ncfg), 1);
      chk("R1 reset dclk", int'(dclk), 0);
      chk("R1 reset ce_n", int'(ce_n), 1);
      chk("R1 reset err", int'(err_o), 0);
      cyc(1);
      rst_n = 1'b1;
      cyc(6);
      // R2 no start without grant
      chk("R2 idle busy", int'(busy), 0);
      chk("R2 idle ce_n", int'(ce_n), 1);

      // normal load, late status
      page = 2'd1; grant = 1'b1;
      cyc(NC + 8);
      chk("R4 wait status no read", int'(ce_n), 1);
      chk("R4 wait status busy", int'(busy), 1);
      status = 1'b1;
      wait_state(5);
      cyc(2 * H * EX + 3);
      done = 1'b1;
      cyc(2);
      chk("R9 done reached", int'(done_o), 1);
      done = 1'b0;

      // status loss in a shift
      page = 2'd2;
      pulse_restart();
      wait_state(4);
      cyc(1);
      status = 1'b0;
      cyc(2);
      chk("R8 status loss", int'(err_o), 1);
      status = 1'b1;

      // grant drop in the third read
      page = 2'd3;
      pulse_restart();
      while (!(ms == 3 && midx == 2)) cyc(1);
      grant = 1'b0;
      #1;
      chk("R2 release ce_n", int'(ce_n), 1);
      chk("R2 release drive", int'(drive), 0);
      cyc(1);
      chk("R2 grant drop err", int'(err_o), 1);
      pulse_restart();
      chk("R2 restart without grant", int'(err_o), 1);
      grant = 1'b1;

      // done never rises
      page = 2'd0;
      pulse_restart();
      wait_state(5);
      cyc(TO + 2);
      chk("R10 done timeout", int'(err_o), 1);

      // status never rises
      status = 1'b0;
      pulse_restart();
      cyc(NC + TO + 3);
      chk("R4 status timeout", int'(err_o), 1);
      status = 1'b1;

      // reset during a load
      pulse_restart();
      wait_state(3);
      cyc(3);
      rst_n = 1'b0;
      #1;
      chk("R1 mid reset busy", int'(busy), 0);
      chk("R1 mid reset drive", int'(drive), 0);
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      chk("R3 restart after reset", int'(ncfg), 0);
      wait_state(5);
      done = 1'b1;
      cyc(3);
      chk("R9 second completion", int'(done_o), 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule